// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a simple host request port to an external 16K x 4 asynchronous static RAM. The memory has 14 address lines, a shared 4-bit data bus, and three active-low controls: chip select, write strobe and output enable. The host raises a request along with a direction bit, an address and write data. The controller then produces a complete memory cycle from whole clock cycles and reports completion with a one-cycle done pulse. For reads, the captured word is presented on that same pulse.

Every timing count comes from parameters. These are the clock period and the memory's minimum write-strobe width and address access time, each rounded up to whole cycles. With a 10 ns clock, a 12 ns strobe and a 15 ns access time, this gives two cycles of strobe and two cycles of read access.

The shared data bus is modelled as three signals: an output value, an output-enable and an input value. The controller never drives the bus while the memory's outputs are enabled. It also inserts a quiet cycle after every read before it can drive write data. Between accesses the chip select is held high, so the memory sits in its low-power deselected state.

States:
- `ST_IDLE`: ready, memory deselected.
- `ST_RD_ACCESS`: chip select and output enable low, held for the access count.
- `ST_RD_GAP`: done pulse with read data, bus quiet.
- `ST_WR_SETUP`: chip select low, data driven, strobe high.
- `ST_WR_PULSE`: strobe low, held for the strobe count.
- `ST_WR_HOLD`: strobe back high, data and address still held, done pulse.

Transitions:
- `ST_IDLE` to `ST_RD_ACCESS` or `ST_WR_SETUP` on an accepted request.
- `ST_RD_ACCESS` to `ST_RD_GAP` when the access count expires.
- `ST_RD_GAP` to `ST_IDLE`.
- `ST_WR_SETUP` to `ST_WR_PULSE`.
- `ST_WR_PULSE` to `ST_WR_HOLD` when the strobe count expires.
- `ST_WR_HOLD` to `ST_IDLE`.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, ready is 1, done is 0, all three memory controls are 1, and the data bus is not driven.
- R2: Whenever ready is 1, chip select is high and the data bus is not driven. Ready is 1 only when no access is in progress.
- R3: A request is taken only in a cycle where ready is 1. Ready drops on the next cycle. A request raised and withdrawn while ready is 0 starts no memory cycle.
- R4: A write (wr=1) runs in four phases, in order:
  - one cycle with chip select low, strobe high and data driven;
  - exactly two cycles with the strobe low;
  - one cycle with the strobe high while chip select stays low and data stays driven;
  - then chip select returns high.
  The strobe is never low unless chip select is low, output enable is high and data is driven.
- R5: A read (wr=0) holds chip select and output enable low, with the strobe high and the bus undriven, for exactly two cycles.
- R6: On the cycle after a read's access window, done is 1 and rdata equals the word stored at the read address. rdata keeps that value until the next read completes, including across writes.
- R7: Every access produces exactly one done cycle. For a write, done is 1 in the strobe-high hold cycle. For a read, it is 1 in the cycle after the access window.
- R8: The bus is never driven while output enable is low. In the cycle after output enable was low, the bus is also not driven.
- R9: While chip select stays low, the memory address does not change, and it equals the address accepted with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host access request, sampled when ready is 1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 14 | Host word address |
| wdata | input | 4 | Host write data |
| ready | output | 1 | Controller idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Registered read data |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 14 | Memory address |
| sram_dq_out | output | 4 | Data bus value driven by the controller |
| sram_dq_oe | output | 1 | Controller drives the data bus when 1 |
| sram_dq_in | input | 4 | Data bus value seen from the memory |

## Verification
The assertions check the bus rules on every cycle:
- the strobe only inside chip select, with data driven;
- no drive while output enable is low, or on the cycle after it;
- data still driven on the cycle the strobe rises;
- a stable address throughout each chip-select window;
- a deselected memory whenever ready is 1;
- single-cycle done pulses.

Other behaviours need the bench's scenarios and its behavioural memory model:
- the exact phase lengths of a write and a read;
- that the captured word is the stored word, after a model access delay that a shorter window would miss;
- that rdata survives writes;
- that a request withdrawn while busy leaves the memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_ACCESS = 3'd1,
        ST_RD_GAP    = 3'd2,
        ST_WR_SETUP  = 3'd3,
        ST_WR_PULSE  = 3'd4,
        ST_WR_HOLD   = 3'd5
    } ctrl_state_t;

    function automatic int cycles_for(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rdata_capture.sv
module sram_rdata_capture #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (capture) begin
            held <= bus_in;
        end
    end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW        = 14,
    parameter int DW        = 4,
    parameter int CLK_NS    = 10,
    parameter int T_WP_NS   = 12,
    parameter int T_AA_NS   = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);

    localparam int WE_CYC  = cycles_for(T_WP_NS, CLK_NS);
    localparam int RD_CYC  = cycles_for(T_AA_NS, CLK_NS);
    localparam int MAX_CYC = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    ctrl_state_t   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          accept;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          capture;

    assign accept = (state_q == ST_IDLE) && req;

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

    // Next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (wr) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACCESS: if (tmr_expired) state_d = ST_RD_GAP;
            ST_RD_GAP:    state_d = ST_IDLE;
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CW'(WE_CYC - 1);
            end
            ST_WR_PULSE:  if (tmr_expired) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        ready      = 1'b0;
        done       = 1'b0;
        sram_ce_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready = 1'b1;
            ST_RD_ACCESS: begin
                sram_ce_n = 1'b0;
                sram_oe_n = 1'b0;
            end
            ST_RD_GAP:    done = 1'b1;
            ST_WR_SETUP: begin
                sram_ce_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                sram_ce_n  = 1'b0;
                sram_we_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                sram_ce_n  = 1'b0;
                sram_dq_oe = 1'b1;
                done       = 1'b1;
            end
            default: ;
        endcase
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign capture     = (state_q == ST_RD_ACCESS) && tmr_expired;

    sram_cycle_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rdata_capture #(.DW(DW)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .bus_in  (sram_dq_in),
        .held    (rdata)
    );

    // R2
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_ce_n && !sram_dq_oe));

    // R3
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);

    // R4
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));

    // R4
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sram_oe_n) |-> !sram_dq_oe);

    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

endmodule

// File: tb/test_sram_port_ctrl.sv
module test_sram_port_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [13:0] addr = '0;
    logic [3:0]  wdata = '0;
    logic        ready, done;
    logic [3:0]  rdata;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [13:0] sram_addr;
    logic [3:0]  sram_dq_out;
    logic [3:0]  sram_dq_in;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_port_ctrl i_sram_port_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .ready(ready), .done(done), .rdata(rdata),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    // Behavioural memory: write on strobe rise, data valid one clock after access starts
    logic [3:0] mem [int];
    int         rd_age = 0;
    logic [13:0] rd_addr_prev = '0;

    function automatic logic [3:0] mem_word(input logic [13:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 4'h0;
    endfunction

    always @(posedge sram_we_n) begin
        if (rst_n && !sram_ce_n && sram_dq_oe) mem[int'(sram_addr)] = sram_dq_out;
    end

    always @(posedge clk) begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n && (rd_age == 0 || sram_addr == rd_addr_prev))
            rd_age <= rd_age + 1;
        else
            rd_age <= 0;
        rd_addr_prev <= sram_addr;
    end

    assign sram_dq_in = (rd_age >= 1) ? mem_word(sram_addr) : ~mem_word(sram_addr);

    // Continuous bus monitor
    bit oe_was_low = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_dq_oe && (!sram_oe_n || oe_was_low)) begin
                errors++;
                $display("FAIL R8: bus driven oe_n=%0b prev_oe_low=%0b (expected no drive)", sram_oe_n, oe_was_low);
            end
            if (ready && (!sram_ce_n || sram_dq_oe)) begin
                errors++;
                $display("FAIL R2: ready with ce_n=%0b dq_oe=%0b (expected 1,0)", sram_ce_n, sram_dq_oe);
            end
        end
        oe_was_low = rst_n && !sram_oe_n;
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic ctl(input string tag, input logic ce, input logic we, input logic oe,
                       input logic dq, input logic dn);
        check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, done} == {ce, we, oe, dq, dn}, tag,
              "ce,we,oe,dq_oe,done", int'({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, done}),
              int'({ce, we, oe, dq, dn}));
    endtask

    task automatic do_write(input logic [13:0] a, input logic [3:0] d);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; addr = ~a; wdata = ~d;
        check(!ready, "R3", "ready after accept", ready, 0);
        ctl("R4", 0, 1, 1, 1, 0);
        check(sram_addr == a && sram_dq_out == d, "R9", "write addr/data", int'({sram_addr, sram_dq_out}), int'({a, d}));
        @(negedge clk); ctl("R4", 0, 0, 1, 1, 0);
        @(negedge clk); ctl("R4", 0, 0, 1, 1, 0);
        @(negedge clk); ctl("R7", 0, 1, 1, 1, 1);
        check(sram_addr == a && sram_dq_out == d, "R4", "hold addr/data", int'({sram_addr, sram_dq_out}), int'({a, d}));
        @(negedge clk); ctl("R4", 1, 1, 1, 0, 0);
        check(ready, "R2", "ready after write", ready, 1);
    endtask

    task automatic do_read(input logic [13:0] a, input logic [3:0] exp);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0; addr = ~a;
        ctl("R5", 0, 1, 0, 0, 0);
        check(sram_addr == a, "R9", "read addr", sram_addr, a);
        @(negedge clk); ctl("R5", 0, 1, 0, 0, 0);
        @(negedge clk); ctl("R7", 1, 1, 1, 0, 1);
        check(rdata == exp, "R6", "rdata", rdata, exp);
        @(negedge clk);
        check(ready && !done, "R7", "ready,done after read", int'({ready, done}), 2);
        check(rdata == exp, "R6", "rdata held", rdata, exp);
    endtask

    task automatic test_reset;
        @(negedge clk);
        check(ready && !done, "R1", "ready,done in reset", int'({ready, done}), 2);
        ctl("R1", 1, 1, 1, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ctl("R1", 1, 1, 1, 0, 0);
        check(ready, "R1", "ready after reset", ready, 1);
    endtask

    task automatic test_patterns;
        do_write(14'h0000, 4'hA);
        do_write(14'h3FFF, 4'h5);
        do_write(14'h1234, 4'hF);
        do_read(14'h0000, 4'hA);
        do_read(14'h3FFF, 4'h5);
        do_write(14'h0001, 4'h0);
        do_read(14'h1234, 4'hF);
        do_read(14'h0001, 4'h0);
    endtask

    task automatic test_rdata_kept;
        do_read(14'h3FFF, 4'h5);
        do_write(14'h0222, 4'h9);
        check(rdata == 4'h5, "R6", "rdata across write", rdata, 5);
        do_read(14'h0222, 4'h9);
        do_write(14'h0222, 4'h6);
        do_read(14'h0222, 4'h6);
    endtask

    task automatic test_busy_request;
        int ce_low = 0;
        req = 1'b1; wr = 1'b0; addr = 14'h0222;
        @(negedge clk);
        wr = 1'b1; addr = 14'h0333; wdata = 4'hC;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check(done, "R7", "done of read", done, 1);
        check(rdata == 4'h6, "R6", "rdata of busy read", rdata, 6);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!sram_ce_n) ce_low++;
        end
        check(ce_low == 0, "R3", "ce_n low cycles after withdrawn req", ce_low, 0);
        do_read(14'h0333, 4'h0);
    endtask

    initial begin
        test_reset();
        test_patterns();
        test_rdata_kept();
        test_busy_request();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", 5000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule